// File: doc/BRIEF.md
# Edge Timestamp Assembly Channel

This block turns each level change on a monitored input into a fixed-point timestamp. The integer part of the timestamp counts clock cycles and comes from a free-running coarse counter. The fractional part is the position of the edge inside the clock period, derived from an encoded delay-line tap index. A small lookup table, written by a separate calibration engine, converts that index into a calibrated delay. The block adds a per-channel de-skew offset to the result and reports each edge as a one-cycle strobe. The strobe carries the edge polarity, the timestamp and the raw tap index.

The coarse counter can be zeroed synchronously to align several channels to a common origin. It signals each natural wraparound with a one-cycle pulse, so that software-side logic can extend the count. The tap index arrives already encoded, valid in the same cycle the edge is sampled. The datapath is fully pipelined, so any input whose levels each last at least three clock cycles is reported edge by edge.

Top module: `tdc_ts_channel`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ev_strobe`, `ovf` and `ev_time` are 0. The coarse counter starts from 0 at the last reset edge.
- R2: The coarse count advances by one on every clock edge, and an edge with `coarse_clr` high loads 0. The integer part of a timestamp is the count held just before the capture edge.
- R3: `ovf` is high for exactly the one cycle after the count steps from all ones to zero. A clear that lands when the count is all ones gives no pulse.
- R4: Every clock edge at which `sig_in` differs from its value sampled one edge earlier is a capture edge. Each capture edge produces exactly one report, with `ev_rising` = 1 for a 0-to-1 change and 0 for a 1-to-0 change.
- R5: `ev_strobe` rises after the sixth rising clock edge, counting the capture edge as the first, and stays high for one cycle only.
- R6: `ev_raw` equals `tap_code` as sampled on the capture edge. Later changes of `tap_code` do not alter that report.
- R7: The fine fraction is 2^FRAC_W minus the table entry addressed by the tap index. A table entry of 0 therefore adds one full cycle to the integer part.
- R8: `ev_time` = (count << FRAC_W) + fine + `deskew`, modulo 2^(COARSE_W+FRAC_W). `deskew` is a two's-complement value sampled on the capture edge, so a negative offset borrows from the integer part.
- R9: A table write (`lut_we` high on a clock edge) is used by every edge captured on a later clock edge.
- R10: Edges spaced three clock cycles apart each produce a correct, separate report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Monitored input, already synchronous |
| tap_code | input | TAP_W | Encoded delay-line tap index for the current cycle |
| deskew | input | COARSE_W+FRAC_W | Two's-complement offset added to each timestamp |
| coarse_clr | input | 1 | Synchronous clear of the coarse counter |
| lut_we | input | 1 | Table write enable from the calibration engine |
| lut_waddr | input | TAP_W | Table write address |
| lut_wdata | input | FRAC_W | Calibrated delay for that tap, in fraction units |
| ev_strobe | output | 1 | One-cycle report strobe |
| ev_rising | output | 1 | 1 for a rising edge, 0 for a falling edge |
| ev_time | output | COARSE_W+FRAC_W | Fixed-point timestamp, FRAC_W fraction bits |
| ev_raw | output | TAP_W | Raw tap index of the report |
| ovf | output | 1 | Coarse counter wrap pulse |

## Verification
The bench sweeps every tap index against positive, zero and negative de-skew values, using a table that includes the extreme entries 0 and full scale. A design that mishandles the fraction carry or the borrow would report a timestamp one cycle off. Edges come three cycles apart while `tap_code` and `deskew` are scrambled right after each capture. A design that lets reports collide or samples its inputs late would return another edge's data. The counter is run through several natural wraps and is also cleared exactly at its all-ones value, which exposes a stray or missing `ovf` pulse. A table entry is rewritten between edges to show that the new value is used at once.

// File: rtl/tdc_ts_pkg.sv
package tdc_ts_pkg;

  // register stages from the capture edge to the report
  localparam int PIPE_DEPTH = 6;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

endpackage

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] STEP     = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= !clr && (cnt == ALL_ONES);
      if (clr) cnt <= '0;
      else     cnt <= cnt + STEP;
    end
  end

endmodule

// File: rtl/tdc_edge_capture.sv
module tdc_edge_capture
  import tdc_ts_pkg::*;
#(
  parameter int CNT_W = 25,
  parameter int TAP_W = 9,
  parameter int TS_W  = 38
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic [TAP_W-1:0] tap_code,
  input  logic [TS_W-1:0]  deskew,
  input  logic [CNT_W-1:0] cnt,
  output logic             cap_v,
  output edge_pol_e        cap_pol,
  output logic [CNT_W-1:0] cap_cnt,
  output logic [TAP_W-1:0] cap_tap,
  output logic [TS_W-1:0]  cap_dsk
);

  logic sig_prev;
  logic level_change;

  assign level_change = (sig_in != sig_prev);

  // previous level follows the input even in reset, so no edge is invented
  always_ff @(posedge clk) begin
    sig_prev <= sig_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_v   <= 1'b0;
      cap_pol <= EDGE_FALL;
      cap_cnt <= '0;
      cap_tap <= '0;
      cap_dsk <= '0;
    end else begin
      cap_v <= level_change;
      if (level_change) begin
        cap_pol <= sig_in ? EDGE_RISE : EDGE_FALL;
        cap_cnt <= cnt;
        cap_tap <= tap_code;
        cap_dsk <= deskew;
      end
    end
  end

endmodule

// File: rtl/tdc_fine_lut.sv
module tdc_fine_lut #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, synchronous read: maps to one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tdc_ts_combine.sv
module tdc_ts_combine
  import tdc_ts_pkg::*;
#(
  parameter int CNT_W = 25,
  parameter int FRAC_W = 13,
  parameter int TAP_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  edge_pol_e               in_pol,
  input  logic [CNT_W-1:0]        in_cnt,
  input  logic [TAP_W-1:0]        in_tap,
  input  logic [CNT_W+FRAC_W-1:0] in_dsk,
  input  logic [FRAC_W-1:0]       lut_rd,
  output logic                    out_strobe,
  output logic                    out_rising,
  output logic [CNT_W+FRAC_W-1:0] out_time,
  output logic [TAP_W-1:0]        out_raw
);

  localparam int TS_W = CNT_W + FRAC_W;
  localparam logic [FRAC_W:0] ONE_UNIT = {1'b1, {FRAC_W{1'b0}}};

  // stage 2: aligned with the table read
  logic              v2;
  edge_pol_e         pol2;
  logic [CNT_W-1:0]  cnt2;
  logic [TAP_W-1:0]  tap2;
  logic [TS_W-1:0]   dsk2;
  // stage 3: fine fraction, may equal one full unit
  logic              v3;
  edge_pol_e         pol3;
  logic [CNT_W-1:0]  cnt3;
  logic [TAP_W-1:0]  tap3;
  logic [TS_W-1:0]   dsk3;
  logic [FRAC_W:0]   fine3;
  // stage 4: fraction plus de-skew fraction, carry kept
  logic              v4;
  edge_pol_e         pol4;
  logic [CNT_W-1:0]  cnt4;
  logic [TAP_W-1:0]  tap4;
  logic [CNT_W-1:0]  dint4;
  logic [FRAC_W-1:0] frac4;
  logic              cy4;
  // stage 5: integer sum
  logic              v5;
  edge_pol_e         pol5;
  logic [TAP_W-1:0]  tap5;
  logic [CNT_W-1:0]  int5;
  logic [FRAC_W-1:0] frac5;

  logic [FRAC_W:0]   fsum;
  logic [CNT_W-1:0]  isum;

  assign fsum = fine3 + {1'b0, dsk3[FRAC_W-1:0]};
  assign isum = cnt4 + dint4 + {{(CNT_W-1){1'b0}}, cy4};

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0; v5 <= 1'b0;
      pol2 <= EDGE_FALL; pol3 <= EDGE_FALL; pol4 <= EDGE_FALL; pol5 <= EDGE_FALL;
      cnt2 <= '0; cnt3 <= '0; cnt4 <= '0;
      tap2 <= '0; tap3 <= '0; tap4 <= '0; tap5 <= '0;
      dsk2 <= '0; dsk3 <= '0;
      fine3 <= '0;
      dint4 <= '0; frac4 <= '0; cy4 <= 1'b0;
      int5 <= '0; frac5 <= '0;
      out_strobe <= 1'b0;
      out_rising <= 1'b0;
      out_time   <= '0;
      out_raw    <= '0;
    end else begin
      v2   <= in_v;
      pol2 <= in_pol;
      cnt2 <= in_cnt;
      tap2 <= in_tap;
      dsk2 <= in_dsk;

      v3    <= v2;
      pol3  <= pol2;
      cnt3  <= cnt2;
      tap3  <= tap2;
      dsk3  <= dsk2;
      fine3 <= ONE_UNIT - {1'b0, lut_rd};

      v4    <= v3;
      pol4  <= pol3;
      cnt4  <= cnt3;
      tap4  <= tap3;
      dint4 <= dsk3[TS_W-1:FRAC_W];
      frac4 <= fsum[FRAC_W-1:0];
      cy4   <= fsum[FRAC_W];

      v5    <= v4;
      pol5  <= pol4;
      tap5  <= tap4;
      int5  <= isum;
      frac5 <= frac4;

      out_strobe <= v5;
      if (v5) begin
        out_rising <= (pol5 == EDGE_RISE);
        out_time   <= {int5, frac5};
        out_raw    <= tap5;
      end
    end
  end

endmodule

// File: rtl/tdc_ts_channel.sv
module tdc_ts_channel
  import tdc_ts_pkg::*;
#(
  parameter int COARSE_W = 25,
  parameter int FRAC_W   = 13,
  parameter int TAP_W    = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sig_in,
  input  logic [TAP_W-1:0]           tap_code,
  input  logic [COARSE_W+FRAC_W-1:0] deskew,
  input  logic                       coarse_clr,
  input  logic                       lut_we,
  input  logic [TAP_W-1:0]           lut_waddr,
  input  logic [FRAC_W-1:0]          lut_wdata,
  output logic                       ev_strobe,
  output logic                       ev_rising,
  output logic [COARSE_W+FRAC_W-1:0] ev_time,
  output logic [TAP_W-1:0]           ev_raw,
  output logic                       ovf
);

  localparam int TS_W = COARSE_W + FRAC_W;

  logic [COARSE_W-1:0] coarse_cnt;
  logic                cap_v;
  edge_pol_e           cap_pol;
  logic [COARSE_W-1:0] cap_cnt;
  logic [TAP_W-1:0]    cap_tap;
  logic [TS_W-1:0]     cap_dsk;
  logic [FRAC_W-1:0]   lut_rd;

  tdc_coarse_counter #(.W(COARSE_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (coarse_clr),
    .cnt  (coarse_cnt),
    .wrap (ovf)
  );

  tdc_edge_capture #(.CNT_W(COARSE_W), .TAP_W(TAP_W), .TS_W(TS_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .sig_in   (sig_in),
    .tap_code (tap_code),
    .deskew   (deskew),
    .cnt      (coarse_cnt),
    .cap_v    (cap_v),
    .cap_pol  (cap_pol),
    .cap_cnt  (cap_cnt),
    .cap_tap  (cap_tap),
    .cap_dsk  (cap_dsk)
  );

  tdc_fine_lut #(.ADDR_W(TAP_W), .DATA_W(FRAC_W)) u_lut (
    .clk   (clk),
    .we    (lut_we),
    .waddr (lut_waddr),
    .wdata (lut_wdata),
    .raddr (cap_tap),
    .rdata (lut_rd)
  );

  tdc_ts_combine #(.CNT_W(COARSE_W), .FRAC_W(FRAC_W), .TAP_W(TAP_W)) u_comb (
    .clk        (clk),
    .rst        (rst),
    .in_v       (cap_v),
    .in_pol     (cap_pol),
    .in_cnt     (cap_cnt),
    .in_tap     (cap_tap),
    .in_dsk     (cap_dsk),
    .lut_rd     (lut_rd),
    .out_strobe (ev_strobe),
    .out_rising (ev_rising),
    .out_time   (ev_time),
    .out_raw    (ev_raw)
  );

endmodule

// File: rtl/tdc_ts_channel_chk.sv
module tdc_ts_channel_chk
  import tdc_ts_pkg::*;
#(
  parameter int COARSE_W = 25,
  parameter int TAP_W    = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                sig_in,
  input logic [TAP_W-1:0]    tap_code,
  input logic                coarse_clr,
  input logic                ev_strobe,
  input logic                ev_rising,
  input logic [TAP_W-1:0]    ev_raw,
  input logic                ovf,
  input logic [COARSE_W-1:0] coarse_cnt
);

  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 3'd0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  AST_STROBE_HAS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (ev_strobe && since_rst >= 3'd6) |-> ($past(sig_in, PIPE_DEPTH) != $past(sig_in, PIPE_DEPTH + 1))); // R5
  AST_EDGE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6 && $past(sig_in, PIPE_DEPTH) != $past(sig_in, PIPE_DEPTH + 1)) |-> ev_strobe); // R4
  AST_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (ev_strobe && since_rst >= 3'd6) |-> (ev_rising == $past(sig_in, PIPE_DEPTH))); // R4
  AST_RAW_CODE: assert property (@(posedge clk) disable iff (rst)
    (ev_strobe && since_rst >= 3'd6) |-> (ev_raw == $past(tap_code, PIPE_DEPTH))); // R6
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovf |=> !ovf); // R3
  AST_OVF_NOT_ON_CLR: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $past(coarse_clr)) |-> !ovf); // R3
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $past(coarse_clr)) |-> (coarse_cnt == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && !$past(coarse_clr)) |-> (coarse_cnt == $past(coarse_cnt) + COARSE_W'(1))); // R2

endmodule

bind tdc_ts_channel tdc_ts_channel_chk #(.COARSE_W(COARSE_W), .TAP_W(TAP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sig_in     (sig_in),
  .tap_code   (tap_code),
  .coarse_clr (coarse_clr),
  .ev_strobe  (ev_strobe),
  .ev_rising  (ev_rising),
  .ev_raw     (ev_raw),
  .ovf        (ovf),
  .coarse_cnt (coarse_cnt)
);

// File: tb/test_tdc_ts_channel.sv
module test_tdc_ts_channel;

  localparam int CW  = 5;
  localparam int FW  = 6;
  localparam int TW  = 3;
  localparam int TSW = CW + FW;
  localparam int CMOD = 1 << CW;
  localparam int FONE = 1 << FW;
  localparam int TSMOD = 1 << TSW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sig_in = 1'b0;
  logic [TW-1:0]  tap_code = '0;
  logic [TSW-1:0] deskew = '0;
  logic           coarse_clr = 1'b0;
  logic           lut_we = 1'b0;
  logic [TW-1:0]  lut_waddr = '0;
  logic [FW-1:0]  lut_wdata = '0;
  logic           ev_strobe;
  logic           ev_rising;
  logic [TSW-1:0] ev_time;
  logic [TW-1:0]  ev_raw;
  logic           ovf;

  tdc_ts_channel #(.COARSE_W(CW), .FRAC_W(FW), .TAP_W(TW)) i_tdc_ts_channel (
    .clk(clk), .rst(rst), .sig_in(sig_in), .tap_code(tap_code), .deskew(deskew),
    .coarse_clr(coarse_clr), .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .ev_strobe(ev_strobe), .ev_rising(ev_rising), .ev_time(ev_time), .ev_raw(ev_raw), .ovf(ovf)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int clr_edge = 0;
  bit mon_on = 0;
  bit done = 0;

  int    lut_m [1 << TW];
  bit    exp_v [1024];
  bit    exp_pol [1024];
  int    exp_raw [1024];
  int    exp_time [1024];
  string exp_tag [1024];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst || coarse_clr) clr_edge = cyc;
  end

  task automatic chk(input string tag, input int got, input int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at cycle %0d", tag, got, want, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      int slot;
      int ovf_exp;
      ovf_exp = (cyc > clr_edge && ((cyc - clr_edge) % CMOD) == 0) ? 1 : 0;
      chk("R3 ovf", int'(ovf), ovf_exp);
      slot = cyc % 1024;
      if (exp_v[slot]) begin
        chk("R5 strobe", int'(ev_strobe), 1);
        chk("R4 polarity", int'(ev_rising), int'(exp_pol[slot]));
        chk("R6 raw", int'(ev_raw), exp_raw[slot]);
        chk({exp_tag[slot], " time"}, int'(ev_time), exp_time[slot]);
        exp_v[slot] = 0;
      end else begin
        chk("R5 no strobe", int'(ev_strobe), 0);
      end
    end
  end

  task automatic lut_write(input int a, input int d);
    lut_we = 1'b1; lut_waddr = TW'(a); lut_wdata = FW'(d);
    lut_m[a] = d;
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  // called just after a negedge; capture is the next posedge
  task automatic do_edge(input int tap, input int dsk, input string tag);
    int cap;
    int slot;
    int tv;
    cap  = (cyc - clr_edge) % CMOD;
    sig_in   = ~sig_in;
    tap_code = TW'(tap);
    deskew   = TSW'(dsk);
    slot = (cyc + 6) % 1024;
    tv = (cap * FONE + (FONE - lut_m[tap]) + dsk) % TSMOD;
    exp_v[slot]    = 1;
    exp_pol[slot]  = sig_in;
    exp_raw[slot]  = tap;
    exp_time[slot] = tv;
    exp_tag[slot]  = tag;
    @(negedge clk);
    tap_code = ~TW'(tap);
    deskew   = ~TSW'(dsk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_cnt();
    coarse_clr = 1'b1;
    @(negedge clk);
    coarse_clr = 1'b0;
  endtask

  int dsk_set [6] = '{0, 5, TSMOD - 1, 100, TSMOD - 202, FONE - 1};

  initial begin
    for (int i = 0; i < 1024; i++) exp_v[i] = 0;
    repeat (4) @(negedge clk);
    chk("R1 strobe in reset", int'(ev_strobe), 0);
    chk("R1 ovf in reset", int'(ovf), 0);
    chk("R1 time in reset", int'(ev_time), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobe after reset", int'(ev_strobe), 0);
    chk("R1 time after reset", int'(ev_time), 0);
    mon_on = 1;
    // table with the extreme entries 0 and full scale
    for (int i = 0; i < (1 << TW); i++) begin
      int v;
      v = (i == 2) ? 0 : (i == 7) ? FONE - 1 : (i * 13 + 5) % FONE;
      lut_write(i, v);
    end
    repeat (3) @(negedge clk);
    do_edge(1, 0, "R1 R2");
    do_edge(4, 0, "R1 R2");
    // sweep all taps against all offsets, edges three cycles apart
    for (int t = 0; t < (1 << TW); t++)
      for (int d = 0; d < 6; d++)
        do_edge(t, dsk_set[d], "R7 R8 R10");
    clear_cnt();
    repeat (4) @(negedge clk);
    do_edge(2, 0, "R2 R7");
    do_edge(7, TSMOD - 1, "R2 R8");
    // clear when the count is all ones: no wrap pulse (R3)
    while (((cyc - clr_edge) % CMOD) != CMOD - 1) @(negedge clk);
    clear_cnt();
    repeat (70) @(negedge clk);
    lut_write(3, 40);
    do_edge(3, 0, "R9");
    lut_write(3, 1);
    do_edge(3, 7, "R9");
    repeat (10) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got 0 expected 1 (run did not finish)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule